// File: doc/BRIEF.md
# Sense-Reversing Barrier Synchronizer

This block lets a fixed group of participants meet at a common point before any of them moves on. Each participant signals that it has reached the barrier with a single-cycle arrive pulse. The block keeps one sense bit per participant and one shared phase bit. An accepted arrival inverts that participant's sense bit and adds to a shared arrival tally. When the tally reaches the group size, the tally returns to zero and the phase bit takes the sense value that the arrivals have just produced. That new value is the inverse of the old phase.

A participant is waiting while its sense bit differs from the phase bit. It is released when the two match. The block never clears the phase bit on the first arrival, so the barrier can be reused at once. A fast participant that arrives again before a slow one has left only inverts its own sense bit. It then waits for the next phase flip. Arrivals raised by several participants in the same cycle are all counted in that cycle. A pulse from a participant that is already waiting is dropped and reported on a per-participant error output. A one-cycle done pulse marks each phase flip.

Top module: `sense_barrier`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `waiting`, `done` and `arrive_err` are all zero and `phase` is 0.
- R2: An arrive pulse on bit i from a participant that is not waiting sets `waiting[i]` to 1 in the following cycle, unless that pulse completes the barrier.
- R3: The cycle after the pulses that bring the arrival total to NUM_PART, every `waiting` bit is 0, `done` is 1 and `phase` is the inverse of its previous value. The tally then restarts from zero.
- R4: `done` is 1 for exactly one cycle per completion, and `phase` changes in no cycle where `done` is 0.
- R5: Arrive pulses raised on several bits in the same cycle are all counted in that cycle. All NUM_PART bits raised together from idle complete the barrier in one step.
- R6: An arrive pulse on bit i while `waiting[i]` is 1 is not counted and leaves that participant waiting. In the following cycle `arrive_err[i]` is 1, and it returns to 0 one cycle later if no further such pulse occurs.
- R7: A participant that arrives again right after a completion waits and leaves `phase` unchanged. When the rest of the group arrives, the barrier completes again and `phase` returns to its earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| arrive | input | NUM_PART | One-cycle arrival pulse per participant |
| waiting | output | NUM_PART | 1 while that participant is held at the barrier |
| phase | output | 1 | Shared release sense, inverted at each completion |
| done | output | 1 | One-cycle pulse in the cycle `phase` has just flipped |
| arrive_err | output | NUM_PART | One-cycle flag: that participant pulsed while already waiting |

## Verification
The hardest case to reach from the ports is the reuse hazard. One participant must re-enter after a completion while the others have not yet arrived in the new round, and the shared phase must stay unchanged until they do. The stimulus completes a round and, in the very next stimulus step, pulses one participant alone. It checks that this participant waits and that `phase` holds, then brings in the others one at a time. A second hard case is a duplicate pulse landing in the same cycle as the completing pulse of another participant. The bench builds this on purpose and checks that the duplicate is flagged without disturbing the count.

// File: rtl/sb_pkg.sv
package sb_pkg;

    // Polarity of a sense bit; the names only document intent.
    typedef enum logic {
        SENSE_LO = 1'b0,
        SENSE_HI = 1'b1
    } sense_e;

    // What one participant slot decided about its arrive pulse this cycle.
    typedef struct packed {
        logic accept;   // counted arrival
        logic reject;   // pulse while already waiting
    } arr_dec_t;

    // Classify a pulse given whether the slot is currently held.
    function automatic arr_dec_t classify(input logic pulse, input logic held);
        arr_dec_t d;
        d.accept = pulse & ~held;
        d.reject = pulse & held;
        return d;
    endfunction

    // Invert a sense value.
    function automatic sense_e flip(input sense_e s);
        return (s == SENSE_LO) ? SENSE_HI : SENSE_LO;
    endfunction

endpackage

// File: rtl/sb_slot.sv
module sb_slot
    import sb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   arrive,
    input  sense_e phase,
    output logic   accept,
    output logic   waiting,
    output logic   arrive_err
);
    sense_e   local_sense;
    arr_dec_t dec;

    assign waiting = (local_sense != phase);
    assign dec     = classify(arrive, waiting);
    assign accept  = dec.accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            local_sense <= SENSE_LO;
            arrive_err  <= 1'b0;
        end else begin
            if (dec.accept) local_sense <= flip(local_sense);
            arrive_err <= dec.reject;
        end
    end

    // A held participant keeps its sense bit when it pulses again.
    assert_ignored_sense_R6: assert property (@(posedge clk) disable iff (rst)
        (arrive && waiting) |=> (local_sense == $past(local_sense)));

    // An error flag only follows a pulse from a held participant.
    assert_err_cause_R6: assert property (@(posedge clk) disable iff (rst)
        arrive_err |-> ($past(arrive) && $past(waiting)));

endmodule

// File: rtl/sb_tally.sv
module sb_tally #(
    parameter int NUM_PART = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PART-1:0] accept,
    output logic                complete
);
    localparam int CNT_W = $clog2(NUM_PART + 1);
    localparam int SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] pop;
    logic [SUM_W-1:0] sum;

    // Population count of the accepted pulses this cycle.
    always_comb begin
        pop = '0;
        for (int i = 0; i < NUM_PART; i++) begin
            pop = pop + CNT_W'(accept[i]);
        end
    end

    assign sum      = SUM_W'(count) + SUM_W'(pop);
    assign complete = (sum == SUM_W'(NUM_PART));

    always_ff @(posedge clk) begin
        if (rst)           count <= '0;
        else if (complete) count <= '0;
        else               count <= sum[CNT_W-1:0];
    end

    // The tally never holds a full group; a full group completes instead.
    assert_count_below_total_R3: assert property (@(posedge clk) disable iff (rst)
        count < CNT_W'(NUM_PART));

    // Each participant is counted at most once per round, so no overshoot.
    assert_no_overshoot_R5: assert property (@(posedge clk) disable iff (rst)
        sum <= SUM_W'(NUM_PART));

endmodule

// File: rtl/sb_release.sv
module sb_release
    import sb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   complete,
    output sense_e phase,
    output logic   done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= SENSE_LO;
            done  <= 1'b0;
        end else begin
            // The last arrival leaves every slot at flip(phase); adopt it.
            if (complete) phase <= flip(phase);
            done <= complete;
        end
    end

    assert_done_flip_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> (phase != $past(phase)));

    assert_flip_needs_done_R4: assert property (@(posedge clk) disable iff (rst)
        (phase != $past(phase)) |-> done);

endmodule

// File: rtl/sense_barrier.sv
module sense_barrier #(
    parameter int NUM_PART = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PART-1:0] arrive,
    output logic [NUM_PART-1:0] waiting,
    output logic                phase,
    output logic                done,
    output logic [NUM_PART-1:0] arrive_err
);
    import sb_pkg::*;

    logic [NUM_PART-1:0] accept;
    logic                complete;
    sense_e              phase_q;

    for (genvar g = 0; g < NUM_PART; g++) begin : g_slot
        sb_slot u_slot (
            .clk        (clk),
            .rst        (rst),
            .arrive     (arrive[g]),
            .phase      (phase_q),
            .accept     (accept[g]),
            .waiting    (waiting[g]),
            .arrive_err (arrive_err[g])
        );
    end

    sb_tally #(.NUM_PART(NUM_PART)) u_tally (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .complete (complete)
    );

    sb_release u_rel (
        .clk      (clk),
        .rst      (rst),
        .complete (complete),
        .phase    (phase_q),
        .done     (done)
    );

    assign phase = phase_q;

    // After a completion nobody is left held.
    assert_done_clears_wait_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (waiting == '0));

    // Without a completion, a newly accepted participant is held next cycle.
    assert_accept_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (|accept && !complete) |=> ((waiting & $past(accept)) == $past(accept)));

endmodule

// File: tb/sim_sense_barrier.sv
module sim_sense_barrier;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] arrive = '0;
    logic [N-1:0] waiting;
    logic         phase;
    logic         done;
    logic [N-1:0] arrive_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sense_barrier #(.NUM_PART(N)) u0 (
        .clk(clk), .rst(rst), .arrive(arrive),
        .waiting(waiting), .phase(phase), .done(done), .arrive_err(arrive_err)
    );

    task automatic expect_state(input string req, input logic [N-1:0] w,
                                input logic d, input logic p, input logic [N-1:0] e);
        n_cmp++;
        if (waiting !== w || done !== d || phase !== p || arrive_err !== e) begin
            n_bad++;
            $display("FAIL %s: got waiting=%b done=%b phase=%b err=%b, expected waiting=%b done=%b phase=%b err=%b",
                     req, waiting, done, phase, arrive_err, w, d, p, e);
        end
    endtask

    // Pulse arrive for one cycle, then sample after the edge that saw it.
    task automatic pulse_and_check(input logic [N-1:0] a, input string req,
                                   input logic [N-1:0] w, input logic d,
                                   input logic p, input logic [N-1:0] e);
        @(negedge clk) arrive = a;
        @(negedge clk) arrive = '0;
        expect_state(req, w, d, p, e);
    endtask

    task automatic idle_check(input string req, input logic [N-1:0] w, input logic p);
        @(negedge clk);
        expect_state(req, w, 1'b0, p, '0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        expect_state("R1 during reset", '0, 1'b0, 1'b0, '0);
        rst = 1'b0;
        @(negedge clk);
        expect_state("R1 after reset", '0, 1'b0, 1'b0, '0);
    endtask

    task automatic t_one_by_one();
        pulse_and_check(4'b0001, "R2 first arrival",  4'b0001, 1'b0, 1'b0, '0);
        pulse_and_check(4'b0010, "R2 second arrival", 4'b0011, 1'b0, 1'b0, '0);
        pulse_and_check(4'b0100, "R2 third arrival",  4'b0111, 1'b0, 1'b0, '0);
        pulse_and_check(4'b1000, "R3 last arrival releases", 4'b0000, 1'b1, 1'b1, '0);
        idle_check("R4 done drops after one cycle", 4'b0000, 1'b1);
    endtask

    task automatic t_all_at_once();
        pulse_and_check(4'b1111, "R5 all together", 4'b0000, 1'b1, 1'b0, '0);
        idle_check("R4 phase holds without done", 4'b0000, 1'b0);
    endtask

    task automatic t_pairs();
        pulse_and_check(4'b0101, "R5 pair counted", 4'b0101, 1'b0, 1'b0, '0);
        pulse_and_check(4'b1010, "R5 second pair completes", 4'b0000, 1'b1, 1'b1, '0);
    endtask

    task automatic t_duplicate();
        pulse_and_check(4'b0001, "R2 arrival before duplicate", 4'b0001, 1'b0, 1'b1, '0);
        pulse_and_check(4'b0011, "R6 duplicate flagged", 4'b0011, 1'b0, 1'b1, 4'b0001);
        idle_check("R6 flag clears", 4'b0011, 1'b1);
        // Tally must be 2: two more arrivals complete exactly.
        pulse_and_check(4'b1100, "R6 duplicate not counted", 4'b0000, 1'b1, 1'b0, '0);
    endtask

    task automatic t_reuse();
        pulse_and_check(4'b0011, "R7 round A part", 4'b0011, 1'b0, 1'b0, '0);
        pulse_and_check(4'b1100, "R7 round A completes", 4'b0000, 1'b1, 1'b1, '0);
        pulse_and_check(4'b0001, "R7 early re-entry waits", 4'b0001, 1'b0, 1'b1, '0);
        pulse_and_check(4'b0010, "R7 phase held", 4'b0011, 1'b0, 1'b1, '0);
        pulse_and_check(4'b0100, "R7 third of round B", 4'b0111, 1'b0, 1'b1, '0);
        // Duplicate from bit 0 together with the completing bit 3.
        pulse_and_check(4'b1001, "R7 round B completes with duplicate",
                        4'b0000, 1'b1, 1'b0, 4'b0001);
        idle_check("R4 quiet after round B", 4'b0000, 1'b0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        t_reset();
        t_one_by_one();
        t_all_at_once();
        t_pairs();
        t_duplicate();
        t_reuse();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule